// File: doc/BRIEF.md
# Shadowed SRAM Autostore Controller

This block is a clocked model of a byte-wide static memory of 2048 locations that keeps a second, nonvolatile copy of its contents. The host side looks like a plain asynchronous SRAM. It has three active-low strobes (chip select, output enable and write strobe), an 11-bit address, a byte in and a byte out, and an output-drive flag that a pad ring can use to steer a shared data bus.

Two digital supply-status inputs drive the power sequencing. One says the supply is above the switch threshold. The other says it has dropped under the reset threshold.

When the supply falls through the switch threshold and the working array has been modified since the last copy, the block copies the working array into the shadow array. It copies one byte per clock. A brown-out under the reset threshold leaves a pending restore behind. When the supply comes back above the switch threshold, that restore copies the shadow array back into the working array. While a copy runs, the block reports itself busy and ignores the host.

Top module: `nvsram_autostore`

## Requirements
- R1: The working array has 2048 bytes selected by `addr[10:0]`. When `cs_n`=0, `oe_n`=0, `wr_n`=1 and `busy`=0, `dq_drive` is 1 and `dq_out` shows the byte at `addr` in the same cycle. It follows address changes with no strobe toggling. Otherwise `dq_drive` is 0 and `dq_out` is 0.
- R2: A write cycle lasts while `cs_n` and `wr_n` are both 0. The address and data present in its last cycle are committed at the first rising clock edge where either strobe is high again. The new byte is readable from the next cycle.
- R3: After reset `busy`, `dq_drive` and `corrupt_flag` are 0, the array is marked clean, and no restore is pending.
- R4: While `wr_n` is 0, `dq_drive` is 0 even with `cs_n` and `oe_n` low.
- R5: A 1-to-0 transition of `sup_ok` starts a store only if the array is dirty. The store copies every working byte to the shadow array and holds `busy` high for exactly STORE_CYC cycles. If the array is clean, `busy` stays 0.
- R6: While `sup_brownout` is 1, a restore request is latched. Once `sup_ok` is 1 with a request pending, a restore copies the shadow array into the working array and holds `busy` high for exactly RESTORE_CYC cycles. With no pending request, a return of `sup_ok` starts nothing.
- R7: While `sup_ok` is 0, write cycles change no byte of the working array and do not mark it dirty.
- R8: While `busy` is 1, `dq_drive` is 0 and writes that end are discarded.
- R9: An accepted write marks the array dirty. The end of a store or restore marks it clean, so a later supply drop with no writes in between starts no store.
- R10: If a write cycle is in progress in the last cycle of a restore, `corrupt_flag` is 1 for the one cycle after `busy` falls. The write itself is still committed when it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_drive | output | 1 | Output driver enable |
| sup_ok | input | 1 | Supply above switch threshold |
| sup_brownout | input | 1 | Supply below reset threshold |
| busy | output | 1 | Store or restore in progress |
| corrupt_flag | output | 1 | Write was active at the end of a restore |

## Verification
The hardest situation to reach is a write strobe held low exactly across the last cycle of a restore. To get there, the stimulus first dirties the array, then drops the supply so a store runs, then pulses the brown-out input. It raises the supply and asserts the write strobe one cycle into the restore, holding it until `busy` falls. The clean-array path is reached by dropping the supply straight after a restore with no writes in between, which shows that a copy cleared the dirty state. Random writes and reads with a fixed seed cover the ordinary access paths.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_STORE, OP_RESTORE} nvs_op_e;

  function automatic logic wr_cycle(input logic cs_n, input logic wr_n);
    return !cs_n && !wr_n;
  endfunction

  function automatic logic rd_cycle(input logic cs_n, input logic oe_n, input logic wr_n);
    return !cs_n && !oe_n && wr_n;
  endfunction

  function automatic int op_length(input nvs_op_e op, input int store_cyc, input int restore_cyc);
    return (op == OP_STORE) ? store_cyc : restore_cyc;
  endfunction
endpackage

// File: rtl/nvs_access.sv
module nvs_access
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              busy,
  input  logic              sup_ok,
  output logic              wr_now,
  output logic              wr_accept,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en
);
  logic wr_q;

  assign wr_now = wr_cycle(cs_n, wr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_q <= wr_now;
      if (wr_now) begin
        wr_addr <= addr;
        wr_data <= dq_in;
      end
    end
  end

  assign wr_accept = wr_q && !wr_now && sup_ok && !busy;
  assign rd_en     = rd_cycle(cs_n, oe_n, wr_n) && !busy;
endmodule

// File: rtl/nvs_power_seq.sv
module nvs_power_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int STORE_CYC   = 2080,
  parameter int RESTORE_CYC = 2064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_ok,
  input  logic              sup_brownout,
  input  logic              wr_accept,
  input  logic              wr_now,
  output logic              busy,
  output logic              dirty,
  output logic              restore_req,
  output logic              store_start,
  output logic              restore_start,
  output logic              op_last,
  output logic              op_is_store,
  output logic              op_is_restore,
  output logic              copy_en,
  output logic [ADDR_W-1:0] copy_idx,
  output logic              corrupt_flag
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MAX_CYC = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  nvs_op_e    op;
  logic [CNT_W-1:0] op_cnt;
  logic       sup_q;
  logic       sup_fell;

  assign sup_fell      = sup_q && !sup_ok;
  assign busy          = (op != OP_IDLE);
  assign op_is_store   = (op == OP_STORE);
  assign op_is_restore = (op == OP_RESTORE);
  assign store_start   = (op == OP_IDLE) && sup_fell && dirty;
  assign restore_start = (op == OP_IDLE) && !store_start && sup_ok && restore_req;
  assign op_last       = busy && (int'(op_cnt) == op_length(op, STORE_CYC, RESTORE_CYC) - 1);
  assign copy_en       = busy && (int'(op_cnt) < DEPTH);
  assign copy_idx      = op_cnt[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op           <= OP_IDLE;
      op_cnt       <= '0;
      sup_q        <= 1'b0;
      dirty        <= 1'b0;
      restore_req  <= 1'b0;
      corrupt_flag <= 1'b0;
    end else begin
      sup_q        <= sup_ok;
      corrupt_flag <= op_last && op_is_restore && wr_now;
      if (store_start) begin
        op     <= OP_STORE;
        op_cnt <= '0;
      end else if (restore_start) begin
        op     <= OP_RESTORE;
        op_cnt <= '0;
      end else if (op_last) begin
        op     <= OP_IDLE;
        op_cnt <= '0;
      end else if (busy) begin
        op_cnt <= op_cnt + 1'b1;
      end
      if (sup_brownout)       restore_req <= 1'b1;
      else if (restore_start) restore_req <= 1'b0;
      if (wr_accept)    dirty <= 1'b1;
      else if (op_last) dirty <= 1'b0;
    end
  end
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              copy_en,
  input  logic              copy_to_shadow,
  input  logic [ADDR_W-1:0] copy_idx,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_mem   [DEPTH];
  logic [DATA_W-1:0] shadow_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (copy_en && !copy_to_shadow) work_mem[copy_idx] <= shadow_mem[copy_idx];
    else if (wr_accept)             work_mem[wr_addr]  <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (copy_en && copy_to_shadow) shadow_mem[copy_idx] <= work_mem[copy_idx];
  end

  assign rd_data = work_mem[rd_addr];
endmodule

// File: rtl/nvsram_autostore.sv
module nvsram_autostore
  import nvs_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int STORE_CYC   = 2080,
  parameter int RESTORE_CYC = 2064
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  input  logic              sup_ok,
  input  logic              sup_brownout,
  output logic              busy,
  output logic              corrupt_flag
);
  logic              wr_now, wr_accept, rd_en;
  logic [ADDR_W-1:0] wr_addr, copy_idx;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic dirty, restore_req, store_start, restore_start, op_last;
  logic op_is_store, op_is_restore, copy_en;

  nvs_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_access (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
    .addr(addr), .dq_in(dq_in), .busy(busy), .sup_ok(sup_ok),
    .wr_now(wr_now), .wr_accept(wr_accept), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en)
  );

  nvs_power_seq #(.ADDR_W(ADDR_W), .STORE_CYC(STORE_CYC), .RESTORE_CYC(RESTORE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .sup_brownout(sup_brownout),
    .wr_accept(wr_accept), .wr_now(wr_now), .busy(busy), .dirty(dirty),
    .restore_req(restore_req), .store_start(store_start),
    .restore_start(restore_start), .op_last(op_last),
    .op_is_store(op_is_store), .op_is_restore(op_is_restore),
    .copy_en(copy_en), .copy_idx(copy_idx), .corrupt_flag(corrupt_flag)
  );

  nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arrays (
    .clk(clk), .wr_accept(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data),
    .copy_en(copy_en), .copy_to_shadow(op_is_store), .copy_idx(copy_idx),
    .rd_addr(addr), .rd_data(rd_data)
  );

  assign dq_drive = rd_en;
  assign dq_out   = rd_en ? rd_data : '0;
endmodule

// File: rtl/nvsram_autostore_chk.sv
module nvsram_autostore_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_n,
  input logic dq_drive,
  input logic sup_ok,
  input logic busy,
  input logic corrupt_flag,
  input logic wr_accept,
  input logic dirty,
  input logic restore_req,
  input logic op_is_store,
  input logic op_is_restore
);
  AST_WRITE_STROBE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> !dq_drive); // R4
  AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !dq_drive); // R8
  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) ($rose(busy) && op_is_store) |-> $past(dirty)); // R5
  AST_RESTORE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) ($rose(busy) && op_is_restore) |-> $past(restore_req)); // R6
  AST_LOW_SUPPLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !sup_ok |-> !wr_accept); // R7
  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) wr_accept |=> dirty); // R9
  AST_CORRUPT_AT_END: assert property (@(posedge clk) disable iff (!rst_n) corrupt_flag |-> $fell(busy)); // R10
endmodule

bind nvsram_autostore nvsram_autostore_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .dq_drive(dq_drive), .sup_ok(sup_ok),
  .busy(busy), .corrupt_flag(corrupt_flag), .wr_accept(wr_accept), .dirty(dirty),
  .restore_req(restore_req), .op_is_store(op_is_store), .op_is_restore(op_is_restore)
);

// File: tb/nvsram_autostore_tb.sv
module nvsram_autostore_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int ADDR_W      = 11;
  localparam int DATA_W      = 8;
  localparam int DEPTH       = 1 << ADDR_W;
  localparam int STORE_CYC   = 2080;
  localparam int RESTORE_CYC = 2064;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dq_in = '0;
  logic [DATA_W-1:0] dq_out;
  logic dq_drive, busy, corrupt_flag;
  logic sup_ok = 1'b1, sup_brownout = 1'b0;

  int checks = 0, failures = 0;
  logic [DATA_W-1:0] ref_mem [DEPTH];
  bit known [DEPTH];
  int written[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nvsram_autostore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYC(STORE_CYC),
    .RESTORE_CYC(RESTORE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive), .sup_ok(sup_ok),
    .sup_brownout(sup_brownout), .busy(busy), .corrupt_flag(corrupt_flag)
  );

  function automatic bit drive_expected(bit c, bit o, bit w, bit b);
    return !c && !o && w && !b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; oe_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_write(input int a, input int d, input bit expect_ok);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b1; wr_n = 1'b0;
    addr = ADDR_W'(a); dq_in = DATA_W'(d);
    @(negedge clk);
    idle_bus();
    @(negedge clk);
    if (expect_ok) begin
      if (!known[a]) written.push_back(a);
      ref_mem[a] = DATA_W'(d);
      known[a]   = 1'b1;
    end
  endtask

  task automatic do_read(input int a, input string req);
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1; addr = ADDR_W'(a);
    #1;
    chk(dq_drive == drive_expected(cs_n, oe_n, wr_n, busy), req, int'(dq_drive), 1);
    chk(dq_out == ref_mem[a], req, int'(dq_out), int'(ref_mem[a]));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int a0;
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk(busy == 1'b0, "R3 busy", int'(busy), 0);
    chk(dq_drive == 1'b0, "R3 drive", int'(dq_drive), 0);
    chk(corrupt_flag == 1'b0, "R3 corrupt", int'(corrupt_flag), 0);

    // R2/R1 random writes and reads
    for (int i = 0; i < 80; i++) begin
      if (written.size() == 0 || ($urandom % 2) == 0)
        do_write(int'($urandom % DEPTH), int'($urandom % 256), 1'b1);
      else
        do_read(written[$urandom % written.size()], "R1/R2 random read");
    end
    // corner addresses
    do_write(0, 8'hA5, 1'b1);
    do_write(DEPTH-1, 8'h5A, 1'b1);
    do_read(0, "R1 low edge");
    do_read(DEPTH-1, "R1 high edge");
    // R1: output follows address with strobes held
    a0 = written[0];
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b0; wr_n = 1'b1; addr = ADDR_W'(0);
    #1; chk(dq_out == ref_mem[0], "R1 follow a", int'(dq_out), int'(ref_mem[0]));
    addr = ADDR_W'(a0);
    #1; chk(dq_out == ref_mem[a0], "R1 follow b", int'(dq_out), int'(ref_mem[a0]));
    // R4: write strobe low with output enable low
    @(negedge clk);
    wr_n = 1'b0; addr = ADDR_W'(5); dq_in = 8'h3C;
    #1; chk(dq_drive == 1'b0, "R4 drive off", int'(dq_drive), 0);
    @(negedge clk);
    idle_bus();
    @(negedge clk);
    if (!known[5]) written.push_back(5);
    ref_mem[5] = 8'h3C; known[5] = 1'b1;
    do_read(5, "R2 write with oe low");

    // R5: dirty supply drop starts a store
    @(negedge clk);
    idle_bus();
    sup_ok = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R5 store began", int'(busy), 1);
    cs_n = 1'b0; oe_n = 1'b0;
    #1; chk(dq_drive == 1'b0, "R8 no drive while busy", int'(dq_drive), 0);
    idle_bus();
    count_busy(n);
    chk(n == STORE_CYC - 1, "R5 store length", n + 1, STORE_CYC);

    // R7: writes while supply low are dropped
    do_write(0, 8'hFF, 1'b0);
    do_read(0, "R7 low supply write ignored");
    idle_bus();

    // R6: brown-out latches restore, return of supply runs it
    @(negedge clk); sup_brownout = 1'b1;
    repeat (3) @(negedge clk);
    sup_brownout = 1'b0;
    @(negedge clk); sup_ok = 1'b1;
    count_busy(n);
    chk(n == RESTORE_CYC, "R6 restore length", n, RESTORE_CYC);
    do_read(DEPTH-1, "R6 data after restore");
    do_read(a0, "R6 data after restore b");
    idle_bus();

    // R9: clean array, supply drop starts nothing
    @(negedge clk); sup_ok = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(busy == 1'b0, "R9 no store when clean", int'(busy), 0);
    end
    // R6: supply returns with no pending request
    sup_ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(busy == 1'b0, "R6 no restore without request", int'(busy), 0);
    end

    // R10: write held across the end of a restore
    do_write(7, 8'h77, 1'b1);
    @(negedge clk); sup_ok = 1'b0;
    count_busy(n);
    chk(n == STORE_CYC, "R5 second store", n, STORE_CYC);
    @(negedge clk); sup_brownout = 1'b1;
    @(negedge clk); sup_brownout = 1'b0;
    @(negedge clk); sup_ok = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R6 restore began", int'(busy), 1);
    cs_n = 1'b0; oe_n = 1'b1; wr_n = 1'b0; addr = ADDR_W'(9); dq_in = 8'h99;
    n = 1;
    @(negedge clk);
    while (busy && n < 10000) begin n++; @(negedge clk); end
    chk(corrupt_flag == 1'b1, "R10 corrupt flag", int'(corrupt_flag), 1);
    idle_bus();
    @(negedge clk);
    chk(corrupt_flag == 1'b0, "R10 flag one cycle", int'(corrupt_flag), 0);
    if (!known[9]) written.push_back(9);
    ref_mem[9] = 8'h99; known[9] = 1'b1;
    do_read(9, "R10 write still committed");
    do_read(7, "R6 restored dirty byte");
    idle_bus();
    // R9: that write dirtied the array again
    @(negedge clk); sup_ok = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9 dirty after write", int'(busy), 1);
    count_busy(n);
    finish_run();
  end
endmodule